// File: doc/BRIEF.md
# Synchronization Pulse Conditioner

This block turns one of three raw, asynchronous timing references into a clean single-cycle SYNC pulse in the measurement clock domain. It is the front end of a frequency-measurement loop. The downstream error counter reloads on every pulse it receives from here. The block picks an input by a 2-bit select and brings it across into the local clock domain. It treats either the rising or the falling transition as an event. It then lets through only every 2^n-th event, so a fast reference can be slowed to a usable rate.

Software may also ask for a single SYNC pulse. That request skips the prescaler and is merged onto the output. Source, edge sense and divider are held in local configuration registers. Those registers take new values only while the downstream counter is disabled. The active settings are driven back out so the surrounding logic can read them.

Top module: `sync_pulse_conditioner`

## Requirements
- R1: The select code picks the input that is watched: 00 picks `syncRaw[0]`, 01 picks `syncRaw[1]`, 10 picks `syncRaw[2]`. Transitions on unselected inputs never produce a pulse. A qualifying transition that is set up before clock edge k gives a pulse in the cycle after edge k+2.
- R2: With the polarity bit at 0, only 0-to-1 transitions of the selected input are events. With it at 1, only 1-to-0 transitions are events.
- R3: With divider code n (0..7), one pulse is produced for every 2^n events. The first pulse comes on the 2^n-th event after the prescaler was last cleared. Each pulse lasts exactly one cycle.
- R4: A `swReq` strobe sampled at edge k makes `syncPulse` high for the single cycle after edge k. It does this regardless of the prescaler state, and it does not change the prescaler's event count.
- R5: A `cfgWr` strobe loads select, polarity and divider only when `cntEn` is low. While `cntEn` is high the write is ignored and `curSrc`, `curPol` and `curDiv` keep their values.
- R6: After reset, `curSrc` is 10, `curPol` is 0, `curDiv` is 000 and `syncPulse` is low.
- R7: With select code 11, no input transition produces a pulse.
- R8: While `cntEn` is low, the prescaler is held at zero and no input transition produces a pulse. The prescaler also restarts from zero on the edge after the divider code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncRaw | input | 3 | Raw asynchronous reference inputs |
| swReq | input | 1 | One-cycle software request for a SYNC event |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSrcIn | input | 2 | Source select to be written |
| cfgPolIn | input | 1 | Edge polarity to be written (0 rising, 1 falling) |
| cfgDivIn | input | 3 | Divider code to be written (divide by 2^code) |
| cntEn | input | 1 | Downstream counter enable; locks configuration |
| syncPulse | output | 1 | Conditioned single-cycle SYNC pulse |
| curSrc | output | 2 | Active source select |
| curPol | output | 1 | Active polarity |
| curDiv | output | 3 | Active divider code |

## Verification
The prescaler's output pulse and the software event can land in the same cycle. In that case they must merge into one high cycle, and the prescaler's count must not be disturbed. The bench provokes this by raising the selected input while the divider is at /1. It then issues `swReq` so that it is sampled on the very edge where the prescaler pulse appears. A cycle-accurate behavioural model judges the result. It checks that the output stays high for only that one cycle, and that later divided pulses keep their normal spacing.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;
  localparam int DIV_W   = 3;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic             pol;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic clrCnt;
    logic swFire;
  } strobe_t;

  localparam cfg_t CFG_RESET = '{src: 2'b10, pol: 1'b0, div: '0};
endpackage

// File: rtl/sync_cond_ctrl.sv
module sync_cond_ctrl
  import sync_cond_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWr,
  input  cfg_t    cfgIn,
  input  logic    cntEn,
  input  logic    swReq,
  output cfg_t    cfgQ,
  output strobe_t strb
);
  logic [DIV_W-1:0] prevDiv;
  logic             swQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      prevDiv <= CFG_RESET.div;
      swQ     <= 1'b0;
    end else begin
      if (cfgWr && !cntEn) cfgQ <= cfgIn;
      prevDiv <= cfgQ.div;
      swQ     <= swReq;
    end
  end

  always_comb begin
    strb.clrCnt = !cntEn || (cfgQ.div != prevDiv);
    strb.swFire = swQ;
  end

  // R5: configuration cannot move while counting is enabled
  p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> $stable(cfgQ));

  // R4: software event never persists without a new request
  p_sw_selfclear_r4: assert property (@(posedge clk) disable iff (!rstN)
    !swReq |=> !strb.swFire);
endmodule

// File: rtl/sync_cond_dp.sv
module sync_cond_dp
  import sync_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] syncRaw,
  input  cfg_t               cfg,
  input  strobe_t            strb,
  output logic               syncPulse
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [NUM_SRC-1:0] curV, prvV;
  logic               cur, prv, evt;
  logic [CNT_W-1:0]   count;
  logic [CNT_W:0]     lim;
  logic               divPulse;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[SYNC_STAGES-1:0], syncRaw[i]};
    end
    assign curV[i] = sh[SYNC_STAGES-1];
    assign prvV[i] = sh[SYNC_STAGES];
  end

  always_comb begin
    cur = 1'b0;
    prv = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg.src == SRC_W'(i)) begin
        cur = curV[i];
        prv = prvV[i];
      end
    end
    evt = cfg.pol ? (prv && !cur) : (cur && !prv);
    lim = ({{CNT_W{1'b0}}, 1'b1} << cfg.div) - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      divPulse <= 1'b0;
    end else if (strb.clrCnt) begin
      count    <= '0;
      divPulse <= 1'b0;
    end else if (evt) begin
      if ({1'b0, count} == lim) begin
        count    <= '0;
        divPulse <= 1'b1;
      end else begin
        count    <= count + 1'b1;
        divPulse <= 1'b0;
      end
    end else begin
      divPulse <= 1'b0;
    end
  end

  assign syncPulse = divPulse | strb.swFire;

  // R7: the reserved code yields no events
  p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.src == 2'b11) |-> !evt);

  // R3: the count never passes the terminal value of the active divider
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrCnt |-> ({1'b0, count} <= lim));

  // R3: a divided pulse is always caused by an event on the previous edge
  p_pulse_from_event_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divPulse) |-> $past(evt));

  // R8: clearing empties the prescaler on the next edge
  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (count == '0) && !divPulse);
endmodule

// File: rtl/sync_pulse_conditioner.sv
module sync_pulse_conditioner
  import sync_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] syncRaw,
  input  logic               swReq,
  input  logic               cfgWr,
  input  logic [SRC_W-1:0]   cfgSrcIn,
  input  logic               cfgPolIn,
  input  logic [DIV_W-1:0]   cfgDivIn,
  input  logic               cntEn,
  output logic               syncPulse,
  output logic [SRC_W-1:0]   curSrc,
  output logic               curPol,
  output logic [DIV_W-1:0]   curDiv
);
  cfg_t    cfgIn, cfgQ;
  strobe_t strb;

  assign cfgIn = '{src: cfgSrcIn, pol: cfgPolIn, div: cfgDivIn};

  sync_cond_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgIn(cfgIn),
    .cntEn(cntEn), .swReq(swReq), .cfgQ(cfgQ), .strb(strb)
  );

  sync_cond_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .syncRaw(syncRaw), .cfg(cfgQ),
    .strb(strb), .syncPulse(syncPulse)
  );

  assign curSrc = cfgQ.src;
  assign curPol = cfgQ.pol;
  assign curDiv = cfgQ.div;
endmodule

// File: tb/tb_sync_pulse_conditioner.sv
module tb_sync_pulse_conditioner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] syncRaw = '0;
  logic       swReq = 1'b0, cfgWr = 1'b0, cfgPolIn = 1'b0, cntEn = 1'b0;
  logic [1:0] cfgSrcIn = '0;
  logic [2:0] cfgDivIn = '0;
  logic       syncPulse, curPol;
  logic [1:0] curSrc;
  logic [2:0] curDiv;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  string phase = "R6";

  always #2 clk = ~clk;

  sync_pulse_conditioner dut (
    .clk(clk), .rstN(rstN), .syncRaw(syncRaw), .swReq(swReq), .cfgWr(cfgWr),
    .cfgSrcIn(cfgSrcIn), .cfgPolIn(cfgPolIn), .cfgDivIn(cfgDivIn), .cntEn(cntEn),
    .syncPulse(syncPulse), .curSrc(curSrc), .curPol(curPol), .curDiv(curDiv)
  );

  // behavioural reference model
  logic [2:0] hq[$] = '{3'b0, 3'b0, 3'b0};
  int  mSrc = 2, mPol = 0, mDiv = 0, mCnt = 0;
  bit  mPulse = 0, mSw = 0, mDivChg = 0, expPulse = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      hq = '{3'b0, 3'b0, 3'b0};
      mSrc = 2; mPol = 0; mDiv = 0; mCnt = 0;
      mPulse = 0; mSw = 0; mDivChg = 0;
    end else begin
      logic [2:0] a, b;
      bit evt, np;
      a = hq[1]; b = hq[2];
      evt = 0;
      if (mSrc != 3) evt = mPol ? (b[mSrc] && !a[mSrc]) : (a[mSrc] && !b[mSrc]);
      np = 0;
      if (!cntEn || mDivChg) mCnt = 0;
      else if (evt) begin
        mCnt++;
        if (mCnt == (1 << mDiv)) begin mCnt = 0; np = 1; end
      end
      mDivChg = 0;
      if (cfgWr && !cntEn) begin
        if (int'(cfgDivIn) != mDiv) mDivChg = 1;
        mSrc = cfgSrcIn; mPol = cfgPolIn; mDiv = cfgDivIn;
      end
      mSw = swReq;
      mPulse = np;
      hq.push_front(syncRaw);
      void'(hq.pop_back());
    end
    expPulse = mPulse | mSw;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(phase, syncPulse, expPulse);
      if (syncPulse) pulses++;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(logic [1:0] s, logic p, logic [2:0] d);
    cfgSrcIn = s; cfgPolIn = p; cfgDivIn = d; cfgWr = 1'b1;
    cyc(1);
    cfgWr = 1'b0;
    cyc(1);
  endtask

  task automatic toggles(int idx, int n);
    for (int i = 0; i < n; i++) begin
      syncRaw[idx] = 1'b1; cyc(3);
      syncRaw[idx] = 1'b0; cyc(3);
    end
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    // R6 reset values
    check("R6", curSrc, 2); check("R6", curPol, 0);
    check("R6", curDiv, 0); check("R6", syncPulse, 0);

    // R1 default source 10 with /1; others ignored; R8 disabled gives nothing
    phase = "R8"; pulses = 0; toggles(2, 3); cyc(4);
    check("R8", pulses, 0);
    cntEn = 1'b1; cyc(2);
    phase = "R1"; pulses = 0; toggles(2, 5); cyc(4);
    check("R1", pulses, 5);
    pulses = 0; toggles(0, 3); toggles(1, 3); cyc(4);
    check("R1", pulses, 0);

    // R2 falling edges on source 00, R3 divide by 4
    cntEn = 1'b0; cyc(1);
    writeCfg(2'b00, 1'b1, 3'd2);
    check("R5", curSrc, 0); check("R2", curPol, 1); check("R3", curDiv, 2);
    cntEn = 1'b1; cyc(2);
    phase = "R2"; pulses = 0; toggles(0, 8); cyc(4);
    check("R3", pulses, 2);

    // R5 write while enabled is ignored
    phase = "R5"; writeCfg(2'b01, 1'b0, 3'd0);
    check("R5", curSrc, 0); check("R5", curPol, 1); check("R5", curDiv, 2);

    // R4 software event mid-count does not advance the prescaler
    phase = "R4"; pulses = 0; toggles(0, 2);
    swReq = 1'b1; cyc(1); swReq = 1'b0; cyc(2);
    check("R4", pulses, 1);
    toggles(0, 1); cyc(4);
    check("R4", pulses, 1);
    toggles(0, 1); cyc(4);
    check("R4", pulses, 2);

    // R8 disable clears the partial count
    phase = "R8"; pulses = 0; toggles(0, 3);
    cntEn = 1'b0; cyc(2); cntEn = 1'b1; cyc(2);
    toggles(0, 1); cyc(4);
    check("R8", pulses, 0);
    toggles(0, 3); cyc(4);
    check("R8", pulses, 1);

    // R3 largest divider /128, rising edges on source 01
    cntEn = 1'b0; cyc(1);
    writeCfg(2'b01, 1'b0, 3'd7);
    cntEn = 1'b1; cyc(2);
    phase = "R3"; pulses = 0; toggles(1, 127); cyc(4);
    check("R3", pulses, 0);
    toggles(1, 1); cyc(4);
    check("R3", pulses, 1);

    // R7 reserved code
    cntEn = 1'b0; cyc(1);
    writeCfg(2'b11, 1'b0, 3'd0);
    cntEn = 1'b1; cyc(2);
    phase = "R7"; pulses = 0;
    toggles(0, 2); toggles(1, 2); toggles(2, 2); cyc(4);
    check("R7", pulses, 0);

    // R4 software event colliding with a divided pulse
    cntEn = 1'b0; cyc(1);
    writeCfg(2'b10, 1'b0, 3'd0);
    cntEn = 1'b1; cyc(2);
    phase = "R4"; pulses = 0;
    syncRaw[2] = 1'b1; cyc(2);
    swReq = 1'b1; cyc(1); swReq = 1'b0; cyc(4);
    syncRaw[2] = 1'b0; cyc(4);
    check("R4", pulses, 1);
    toggles(2, 2); cyc(4);
    check("R3", pulses, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule